// File: doc/BRIEF.md
# Tag-Sweep Read Completion Detector

This block decides that a multi-packet read into a host receive buffer has fully landed, without relying on any completion message from the device. When a read is requested, the block first stamps a marker word (the tag) into the last word of every packet-sized chunk of the target buffer. It then launches the read and snoops every word write that reaches the buffer. A chunk counts as settled once its last word has been overwritten by a value other than the tag. Because every chunk is watched, not only the last one, completion is detected correctly even when the packets arrive in any order.

The tag is chosen so that it should not appear in the incoming data. If it does (a collision), the read would never finish, so the block bounds the wait to the product of the maximum queue depth and the maximum latency of one read. When that window expires, it raises a timeout pulse, advances its pseudo-random tag generator, re-stamps every chunk with the new tag and launches the read again. With the default parameters a chunk is 128 bytes (32 words of 32 bits) and a read is 512 bytes, or four chunks.

The controller is a six-state machine. IDLE waits for a request; IDLE to ARM on `start_i`. ARM writes one tag per cycle; ARM to LAUNCH after the last chunk. LAUNCH pulses the read launch for one cycle; LAUNCH to WAIT always. WAIT watches snoops; WAIT to DONE when no chunk is pending, WAIT to EXPIRE when the window runs out first. DONE pulses completion; DONE to IDLE always. EXPIRE pulses timeout and advances the tag; EXPIRE to ARM always.

Top module: `cmpl_tag_monitor`

## Requirements
- R1: After reset, bufw_en_o, rd_launch_o, done_o and timeout_o are low and tag_o equals the seed (nonzero).
- R2: A start_i pulse in IDLE produces one tag write per cycle for chunks 0,1,2,3 in that order; each write has bufw_addr_o = chunk*32+31 (word address, 32 words per chunk) and bufw_data_o = tag_o.
- R3: rd_launch_o is a one-cycle pulse in the cycle directly after the last tag write.
- R4: While waiting, a snoop write whose address bits [4:0] are all ones and whose data differs from tag_o clears the pending state of chunk address[6:5]; a write of the tag value, or to any other word offset, leaves the chunk pending.
- R5: done_o is a one-cycle pulse in the second cycle after the snoop write that clears the last pending chunk, whatever order the chunks were cleared in; it never rises while a chunk is pending.
- R6: Snoop writes during IDLE, ARM and LAUNCH cycles have no effect on the pending chunks.
- R7: If chunks remain pending after 256 waiting cycles (QUEUE_DEPTH*READ_LAT), timeout_o pulses for one cycle in the next cycle, followed by a fresh tag, a new round of tag writes and a new rd_launch_o pulse.
- R8: Each timeout replaces tag t by (t >> 1) xor (t[0] ? 32'h80200003 : 0); tag_o is never zero.
- R9: start_i is ignored when the block is not in IDLE.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request to begin a tagged read |
| snp_vld_i | input | 1 | A data word write into the buffer is observed |
| snp_addr_i | input | 7 | Word address of the observed write within the buffer |
| snp_data_i | input | 32 | Data of the observed write |
| bufw_en_o | output | 1 | Tag write into the buffer |
| bufw_addr_o | output | 7 | Word address of the tag write |
| bufw_data_o | output | 32 | Tag value written |
| rd_launch_o | output | 1 | One-cycle pulse that launches the read |
| done_o | output | 1 | One-cycle pulse: every chunk has settled |
| timeout_o | output | 1 | One-cycle pulse: wait window expired, retry begins |
| tag_o | output | 32 | Tag in use |

## Verification
On every cycle the assertions check that tag writes carry the current tag at a chunk-trailing address, that the launch pulse follows a tag write, that a pending chunk only clears after an observed snoop, that completion is only raised when no chunk was pending, that a timeout is followed by re-arming with a different tag, and that the tag is never zero. Only the bench scenarios can show that out-of-order arrival, tag-valued writes and off-offset writes are handled, that snoops before the wait and starts while busy are ignored, the exact length of the wait window, and the tag sequence over repeated retries.

// File: rtl/ctm_pkg.sv
package ctm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARM,
        ST_LAUNCH,
        ST_WAIT,
        ST_DONE,
        ST_EXPIRE
    } ctm_state_t;

endpackage

// File: rtl/ctm_tag_lfsr.sv
module ctm_tag_lfsr #(
    parameter int          TAG_W = 32,
    parameter logic [31:0] POLY  = 32'h80200003,
    parameter logic [31:0] SEED  = 32'h1ACEB00C
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             adv,
    output logic [TAG_W-1:0] tag
);
    localparam logic [TAG_W-1:0] POLY_W = POLY[TAG_W-1:0];
    localparam logic [TAG_W-1:0] SEED_W = SEED[TAG_W-1:0];
    localparam logic [TAG_W-1:0] START  = (SEED_W == '0) ? TAG_W'(1) : SEED_W;

    logic [TAG_W-1:0] shifted;
    logic [TAG_W-1:0] nxt;

    always_comb begin
        shifted = tag >> 1;
        nxt     = tag[0] ? (shifted ^ POLY_W) : shifted;
        if (nxt == '0) begin
            nxt = TAG_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tag <= START;
        end else if (adv) begin
            tag <= nxt;
        end
    end

endmodule

// File: rtl/ctm_chunk_track.sv
module ctm_chunk_track #(
    parameter int TAG_W    = 32,
    parameter int N_CHUNKS = 4,
    parameter int CW_AW    = 5,
    parameter int IDX_W    = 2,
    parameter int BUF_AW   = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm_en,
    input  logic [IDX_W-1:0]  arm_idx,
    input  logic              watch_en,
    input  logic              snp_vld,
    input  logic [BUF_AW-1:0] snp_addr,
    input  logic [TAG_W-1:0]  snp_data,
    input  logic [TAG_W-1:0]  tag,
    output logic [N_CHUNKS-1:0] pend
);
    logic              trail_hit;
    logic [IDX_W-1:0]  snp_chunk;

    always_comb begin
        trail_hit = snp_vld && watch_en
                 && (snp_addr[CW_AW-1:0] == {CW_AW{1'b1}})
                 && (snp_data != tag);
        snp_chunk = snp_addr[BUF_AW-1:CW_AW];
    end

    for (genvar g = 0; g < N_CHUNKS; g++) begin : g_chunk
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                pend[g] <= 1'b0;
            end else if (arm_en && (arm_idx == IDX_W'(g))) begin
                pend[g] <= 1'b1;
            end else if (trail_hit && (snp_chunk == IDX_W'(g))) begin
                pend[g] <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/ctm_wait_timer.sv
module ctm_wait_timer #(
    parameter int TO_CYC = 256,
    parameter int TMR_W  = 9
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    input  logic run,
    output logic expired
);
    localparam logic [TMR_W-1:0] LAST = TMR_W'(TO_CYC - 1);

    logic [TMR_W-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (run && (cnt != LAST)) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = run && (cnt == LAST);

endmodule

// File: rtl/cmpl_tag_monitor.sv
module cmpl_tag_monitor
    import ctm_pkg::*;
#(
    parameter int          WORD_W      = 32,
    parameter int          CHUNK_BYTES = 128,
    parameter int          N_CHUNKS    = 4,
    parameter int          QUEUE_DEPTH = 4,
    parameter int          READ_LAT    = 64,
    parameter logic [31:0] TAG_POLY    = 32'h80200003,
    parameter logic [31:0] TAG_SEED    = 32'h1ACEB00C,
    localparam int         CHUNK_WORDS = CHUNK_BYTES / (WORD_W / 8),
    localparam int         CW_AW       = $clog2(CHUNK_WORDS),
    localparam int         IDX_W       = (N_CHUNKS > 1) ? $clog2(N_CHUNKS) : 1,
    localparam int         BUF_AW      = CW_AW + IDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              snp_vld_i,
    input  logic [BUF_AW-1:0] snp_addr_i,
    input  logic [WORD_W-1:0] snp_data_i,
    output logic              bufw_en_o,
    output logic [BUF_AW-1:0] bufw_addr_o,
    output logic [WORD_W-1:0] bufw_data_o,
    output logic              rd_launch_o,
    output logic              done_o,
    output logic              timeout_o,
    output logic [WORD_W-1:0] tag_o
);
    localparam int               TO_CYC   = QUEUE_DEPTH * READ_LAT;
    localparam int               TMR_W    = $clog2(TO_CYC + 1);
    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(N_CHUNKS - 1);

    ctm_state_t          state_q;
    ctm_state_t          state_d;
    logic [IDX_W-1:0]    idx_q;
    logic [N_CHUNKS-1:0] pend;
    logic                expired;
    logic [WORD_W-1:0]   tag;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start_i) state_d = ST_ARM;
            ST_ARM:    if (idx_q == LAST_IDX) state_d = ST_LAUNCH;
            ST_LAUNCH: state_d = ST_WAIT;
            ST_WAIT: begin
                if (pend == '0) begin
                    state_d = ST_DONE;
                end else if (expired) begin
                    state_d = ST_EXPIRE;
                end
            end
            ST_DONE:   state_d = ST_IDLE;
            ST_EXPIRE: state_d = ST_ARM;
            default:   state_d = ST_IDLE;
        endcase
    end

    // chunk index walked while arming
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q <= '0;
        end else if (state_q == ST_ARM) begin
            idx_q <= (idx_q == LAST_IDX) ? '0 : idx_q + 1'b1;
        end else begin
            idx_q <= '0;
        end
    end

    // outputs
    always_comb begin
        bufw_en_o   = 1'b0;
        rd_launch_o = 1'b0;
        done_o      = 1'b0;
        timeout_o   = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_ARM:    bufw_en_o   = 1'b1;
            ST_LAUNCH: rd_launch_o = 1'b1;
            ST_WAIT:   ;
            ST_DONE:   done_o      = 1'b1;
            ST_EXPIRE: timeout_o   = 1'b1;
            default:   ;
        endcase
        bufw_addr_o = {idx_q, {CW_AW{1'b1}}};
        bufw_data_o = tag;
        tag_o       = tag;
    end

    ctm_tag_lfsr #(
        .TAG_W (WORD_W),
        .POLY  (TAG_POLY),
        .SEED  (TAG_SEED)
    ) u_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .adv   (state_q == ST_EXPIRE),
        .tag   (tag)
    );

    ctm_chunk_track #(
        .TAG_W    (WORD_W),
        .N_CHUNKS (N_CHUNKS),
        .CW_AW    (CW_AW),
        .IDX_W    (IDX_W),
        .BUF_AW   (BUF_AW)
    ) u_track (
        .clk      (clk),
        .rst_n    (rst_n),
        .arm_en   (state_q == ST_ARM),
        .arm_idx  (idx_q),
        .watch_en (state_q == ST_WAIT),
        .snp_vld  (snp_vld_i),
        .snp_addr (snp_addr_i),
        .snp_data (snp_data_i),
        .tag      (tag),
        .pend     (pend)
    );

    ctm_wait_timer #(
        .TO_CYC (TO_CYC),
        .TMR_W  (TMR_W)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (state_q == ST_LAUNCH),
        .run     (state_q == ST_WAIT),
        .expired (expired)
    );

endmodule

// File: rtl/ctm_chk.sv
module ctm_chk #(
    parameter int WORD_W   = 32,
    parameter int N_CHUNKS = 4,
    parameter int CW_AW    = 5,
    parameter int BUF_AW   = 7
) (
    input logic                clk,
    input logic                rst_n,
    input logic                snp_vld_i,
    input logic                bufw_en_o,
    input logic [BUF_AW-1:0]   bufw_addr_o,
    input logic [WORD_W-1:0]   bufw_data_o,
    input logic                rd_launch_o,
    input logic                done_o,
    input logic                timeout_o,
    input logic [WORD_W-1:0]   tag_o,
    input logic [N_CHUNKS-1:0] pend
);
    // R2
    tagwr_shape_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bufw_en_o |-> (bufw_data_o == tag_o) && (bufw_addr_o[CW_AW-1:0] == {CW_AW{1'b1}}));

    // R3
    launch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_launch_o |=> !rd_launch_o);

    // R3
    launch_after_arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_launch_o |-> $past(bufw_en_o));

    // R4
    clear_needs_snoop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((|($past(pend) & ~pend))) |-> $past(snp_vld_i));

    // R5
    done_all_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(pend) == '0));

    // R5
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    retry_rearm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> bufw_en_o && (tag_o != $past(tag_o)));

    // R8
    tag_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tag_o != '0);

    // R3
    single_event_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({bufw_en_o, rd_launch_o, done_o, timeout_o}));

endmodule

bind cmpl_tag_monitor ctm_chk #(
    .WORD_W   (WORD_W),
    .N_CHUNKS (N_CHUNKS),
    .CW_AW    (CW_AW),
    .BUF_AW   (BUF_AW)
) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .snp_vld_i   (snp_vld_i),
    .bufw_en_o   (bufw_en_o),
    .bufw_addr_o (bufw_addr_o),
    .bufw_data_o (bufw_data_o),
    .rd_launch_o (rd_launch_o),
    .done_o      (done_o),
    .timeout_o   (timeout_o),
    .tag_o       (tag_o),
    .pend        (pend)
);

// File: tb/sim_cmpl_tag_monitor.sv
module sim_cmpl_tag_monitor;
    localparam int          CLK_PERIOD = 10;
    localparam int          NCH        = 4;
    localparam int          CW         = 32;
    localparam int          TO         = 4 * 64;
    localparam logic [31:0] SEED       = 32'h1ACEB00C;
    localparam int          MAXCYC     = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        snp_vld_i = 1'b0;
    logic [6:0]  snp_addr_i = '0;
    logic [31:0] snp_data_i = '0;
    logic        bufw_en_o;
    logic [6:0]  bufw_addr_o;
    logic [31:0] bufw_data_o;
    logic        rd_launch_o;
    logic        done_o;
    logic        timeout_o;
    logic [31:0] tag_o;

    int n_chk = 0;
    int n_fail = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cmpl_tag_monitor u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i),
        .snp_vld_i(snp_vld_i), .snp_addr_i(snp_addr_i), .snp_data_i(snp_data_i),
        .bufw_en_o(bufw_en_o), .bufw_addr_o(bufw_addr_o), .bufw_data_o(bufw_data_o),
        .rd_launch_o(rd_launch_o), .done_o(done_o), .timeout_o(timeout_o), .tag_o(tag_o)
    );

    function automatic logic [31:0] tstep(logic [31:0] t);
        logic [31:0] n;
        n = t >> 1;
        if (t[0]) n = n ^ 32'h80200003;
        if (n == 0) n = 32'd1;
        return n;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // behavioural reference model: phases 0 idle,1 arm,2 launch,3 wait,4 done,5 expire
    int          m_ph;
    int          m_idx;
    int          m_tmr;
    bit          m_pend [NCH];
    logic [31:0] m_tag;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_idx = 0; m_tmr = 0; m_tag = SEED;
            foreach (m_pend[i]) m_pend[i] = 1'b0;
        end else begin
            case (m_ph)
                0: if (start_i) begin m_ph = 1; m_idx = 0; end
                1: begin
                    m_pend[m_idx] = 1'b1;
                    if (m_idx == NCH-1) begin m_ph = 2; m_idx = 0; end
                    else m_idx++;
                end
                2: begin m_ph = 3; m_tmr = 0; end
                3: begin
                    bit any;
                    any = 1'b0;
                    foreach (m_pend[i]) if (m_pend[i]) any = 1'b1;
                    if (snp_vld_i && (int'(snp_addr_i) % CW == CW-1) && snp_data_i != m_tag)
                        m_pend[int'(snp_addr_i) / CW] = 1'b0;
                    if (!any) m_ph = 4;
                    else if (m_tmr == TO-1) m_ph = 5;
                    m_tmr++;
                end
                4: m_ph = 0;
                default: begin m_tag = tstep(m_tag); m_ph = 1; m_idx = 0; end
            endcase
        end
    end

    // per-cycle comparison and event bookkeeping
    int cyc = 0;
    int done_cnt = 0;
    int to_cnt = 0;
    int wr_cnt = 0;
    int t_iss = 0;
    int t_to = 0;

    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            check(bufw_en_o == (m_ph == 1), "R2", "bufw_en_o", 64'(bufw_en_o), 64'(m_ph == 1));
            if (m_ph == 1) begin
                check(bufw_addr_o == 7'(m_idx*CW + CW-1), "R2", "bufw_addr_o",
                      64'(bufw_addr_o), 64'(m_idx*CW + CW-1));
                check(bufw_data_o == m_tag, "R2", "bufw_data_o", 64'(bufw_data_o), 64'(m_tag));
            end
            check(rd_launch_o == (m_ph == 2), "R3", "rd_launch_o", 64'(rd_launch_o), 64'(m_ph == 2));
            check(done_o == (m_ph == 4), "R5", "done_o", 64'(done_o), 64'(m_ph == 4));
            check(timeout_o == (m_ph == 5), "R7", "timeout_o", 64'(timeout_o), 64'(m_ph == 5));
            check(tag_o == m_tag, "R8", "tag_o", 64'(tag_o), 64'(m_tag));
            if (done_o) done_cnt++;
            if (timeout_o) begin to_cnt++; t_to = cyc; end
            if (rd_launch_o) t_iss = cyc;
            if (bufw_en_o) wr_cnt++;
        end
    end

    task automatic tick();
        @(negedge clk);
        #1;
    endtask

    task automatic pulse_start();
        start_i = 1'b1;
        tick();
        start_i = 1'b0;
    endtask

    task automatic snoop(input int addr, input logic [31:0] data);
        snp_vld_i = 1'b1;
        snp_addr_i = 7'(addr);
        snp_data_i = data;
        tick();
        snp_vld_i = 1'b0;
    endtask

    task automatic fill(input int c, input logic [31:0] data);
        snoop(c*CW + CW-1, data);
    endtask

    task automatic wait_launch(input string req);
        int n = 0;
        while (!rd_launch_o && n < 50) begin tick(); n++; end
        check(rd_launch_o, req, "rd_launch_o seen", 64'(rd_launch_o), 64'd1);
    endtask

    task automatic wait_timeout(input string req);
        int n = 0;
        while (!timeout_o && n < TO + 50) begin tick(); n++; end
        check(timeout_o, req, "timeout_o seen", 64'(timeout_o), 64'd1);
    endtask

    task automatic expect_done(input string req);
        check(!done_o, req, "done_o before settle", 64'(done_o), 64'd0);
        tick();
        check(done_o, req, "done_o two cycles after last clear", 64'(done_o), 64'd1);
        tick();
    endtask

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    endtask

    initial begin : watchdog
        repeat (MAXCYC) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual %0d cycles expected below %0d", MAXCYC, MAXCYC);
        report();
    end

    initial begin : stim
        int w0;
        int d0;
        logic [31:0] old;
        repeat (3) tick();
        // R1 reset state
        check(!bufw_en_o && !rd_launch_o && !done_o && !timeout_o, "R1", "outputs in reset",
              64'({bufw_en_o, rd_launch_o, done_o, timeout_o}), 64'd0);
        check(tag_o == SEED, "R1", "tag_o in reset", 64'(tag_o), 64'(SEED));
        rst_n = 1'b1;
        tick();
        check(!bufw_en_o && !done_o, "R1", "idle after reset", 64'({bufw_en_o, done_o}), 64'd0);

        // Scenario A: in-order arrival (R2, R3, R4, R5)
        w0 = wr_cnt;
        pulse_start();
        wait_launch("R3");
        check(wr_cnt - w0 == NCH, "R2", "tag writes per read", 64'(wr_cnt - w0), 64'(NCH));
        tick();
        snoop(3, tag_o ^ 32'h1);               // non-trailing word
        for (int c = 0; c < NCH; c++) fill(c, tag_o ^ 32'(c + 1));
        expect_done("R5");

        // Scenario B: out of order, tag-valued and off-offset writes (R4, R5)
        pulse_start();
        wait_launch("R3");
        tick();
        d0 = done_cnt;
        fill(2, 32'h0);
        fill(0, tag_o ^ 32'hFFFF0000);
        fill(3, 32'h12345678);
        fill(1, tag_o);                        // tag value: stays pending
        snoop(1*CW + 5, 32'hDEAD0001);         // wrong offset: stays pending
        repeat (4) tick();
        check(done_cnt == d0, "R4", "no done while chunk 1 pending", 64'(done_cnt - d0), 64'd0);
        fill(1, 32'hCAFE0001);
        expect_done("R5");

        // Scenario C: early snoops and busy start ignored (R6, R9)
        snoop(0*CW + CW-1, 32'h55AA55AA);      // idle snoop
        pulse_start();
        tick();
        snoop(0*CW + CW-1, 32'h0BADF00D);      // during arming, chunk 0 already stamped
        wait_launch("R3");
        fill(1, 32'h0BADF00E);                 // during launch cycle
        fill(2, 32'h1);
        fill(3, 32'h2);
        w0 = wr_cnt;
        d0 = done_cnt;
        pulse_start();                          // busy: ignored
        repeat (6) tick();
        check(done_cnt == d0, "R6", "early snoops did not settle chunks", 64'(done_cnt - d0), 64'd0);
        check(wr_cnt == w0, "R9", "start while busy gave no tag writes", 64'(wr_cnt - w0), 64'd0);
        fill(0, 32'h3);
        fill(1, 32'h4);
        expect_done("R6");
        repeat (5) tick();
        check(wr_cnt == w0, "R9", "no re-arm after done", 64'(wr_cnt - w0), 64'd0);

        // Scenario D: collision leads to timeout and retry (R7, R8)
        pulse_start();
        wait_launch("R3");
        tick();
        fill(0, 32'h10); fill(1, 32'h11); fill(2, 32'h12);
        old = tag_o;
        wait_timeout("R7");
        check(t_to - t_iss == TO + 1, "R7", "cycles from launch to timeout", 64'(t_to - t_iss), 64'(TO + 1));
        check(tag_o == old, "R8", "tag held during timeout pulse", 64'(tag_o), 64'(old));
        tick();
        check(tag_o == tstep(old), "R8", "fresh tag after timeout", 64'(tag_o), 64'(tstep(old)));
        check(bufw_en_o && bufw_data_o == tstep(old), "R7", "re-arm with fresh tag",
              64'(bufw_data_o), 64'(tstep(old)));
        wait_launch("R7");
        tick();
        for (int c = NCH-1; c >= 0; c--) fill(c, tag_o ^ 32'h5);
        expect_done("R7");

        // Scenario E: two consecutive timeouts (R7, R8)
        old = tag_o;
        d0 = to_cnt;
        pulse_start();
        wait_launch("R3");
        tick();
        wait_timeout("R7");
        tick();
        wait_launch("R7");
        tick();
        wait_timeout("R7");
        check(to_cnt - d0 == 2, "R7", "two timeouts", 64'(to_cnt - d0), 64'd2);
        tick();
        check(tag_o == tstep(tstep(old)), "R8", "tag after two retries",
              64'(tag_o), 64'(tstep(tstep(old))));
        wait_launch("R7");
        tick();
        for (int c = 0; c < NCH; c++) fill(c, ~tag_o);
        expect_done("R5");

        repeat (3) tick();
        report();
    end

endmodule